// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the stream of column addresses a DDR SDRAM burst touches, one address per data beat. A request carries a start column, a burst-length code selecting 2, 4 or 8 beats, and an ordering bit selecting sequential or interleaved order. The request is registered on a clock edge. The first address appears on the output in the following cycle, and one further address follows in each later cycle until the burst is complete.

Every address stays inside the aligned block of columns whose size equals the burst length. The column bits above that block pass through unchanged. The bits below it give the starting beat. Sequential order counts upward and wraps at the block boundary. Interleaved order combines the beat index with the starting offset by exclusive-or. Reads and writes use the same sequence. A request that arrives while a burst is running is ignored, except in the cycle that shows the final beat. A request in that cycle starts the next burst with no idle cycle between the two.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `valid_o` and `last_o` are low and `col_o` is zero.
- R2: Burst-length code `len_i` = 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. `valid_o` is high for exactly that many consecutive cycles.
- R3: When a request is accepted at a clock edge, the next cycle shows `valid_o` high and `col_o` equal to the requested start column.
- R4: With `ilv_i` = 0 (sequential), beat k shows low bits equal to (s + k) mod L. Here L is the burst length and s is the low log2(L) bits of the start column.
- R5: With `ilv_i` = 1 (interleaved), beat k shows low bits equal to s XOR k.
- R6: During a burst, the column bits at and above log2(L) hold the start column's value on every beat.
- R7: `last_o` is high exactly on the final beat of each burst, and never while `valid_o` is low.
- R8: A request (`start_i` high) during any beat except the final one is ignored. The running burst continues with its own column, length and ordering.
- R9: A request during the final beat starts a new burst in the next cycle, with no idle cycle between the two bursts.
- R10: A request with the reserved length code 0 is ignored, and `valid_o` stays low.
- R11: After the final beat, with no new request, `valid_o` and `last_o` return low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request, sampled at each rising edge |
| col_i | input | 10 | Start column of the requested burst |
| len_i | input | 2 | Burst-length code: 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 0 = reserved |
| ilv_i | input | 1 | Ordering: 0 = sequential, 1 = interleaved |
| col_o | output | 10 | Column address of the current beat |
| valid_o | output | 1 | High while `col_o` carries a beat |
| last_o | output | 1 | High on the final beat of a burst |

## Verification
The bench sweeps every length code against both orderings and all eight low start-bit values. Two high-column patterns are used, so the output shows whether the wrap happens at the right block boundary and whether the upper bits are kept. Sequential and interleaved orders give different addresses only for nonzero starting offsets, so the sweep over offsets is what tells the two orderings apart. Separate runs do three more things: they raise a conflicting request in the middle of a burst to show that it is ignored, they raise a request on the final beat to show a gapless hand-over, and they issue the reserved length code to show that no burst starts.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int COL_W  = 10;
    localparam int BEAT_W = 3;
    localparam int LEN_W  = 2;

    typedef struct packed {
        logic              valid;
        logic              last;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] mask;
        logic              ilv;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  col;
    } gen_state_t;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
    parameter int LEN_W  = 2,
    parameter int BEAT_W = 3
) (
    input  logic [LEN_W-1:0]  code_i,
    output logic [BEAT_W-1:0] mask_o,
    output logic              ok_o
);
    // code c selects 2**c beats; mask is the in-block offset mask
    always_comb begin
        ok_o   = (code_i != '0) && (int'(code_i) <= BEAT_W);
        mask_o = '0;
        for (int i = 0; i < BEAT_W; i++) begin
            if (i < int'(code_i)) mask_o[i] = 1'b1;
        end
    end
endmodule

// File: rtl/burst_ord_calc.sv
module burst_ord_calc #(
    parameter int COL_W  = 10,
    parameter int BEAT_W = 3
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] mask_i,
    input  logic              ilv_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [COL_W-1:0]  col_o
);
    logic [BEAT_W-1:0] start_off;
    logic [BEAT_W-1:0] seq_off;
    logic [BEAT_W-1:0] ilv_off;
    logic [BEAT_W-1:0] off;

    assign start_off = base_i[BEAT_W-1:0];
    assign seq_off   = (start_off + beat_i) & mask_i;
    assign ilv_off   = (start_off ^ beat_i) & mask_i;
    assign off       = ilv_i ? ilv_off : seq_off;

    generate
        for (genvar b = 0; b < BEAT_W; b++) begin : g_bit
            assign col_o[b] = mask_i[b] ? off[b] : base_i[b];
        end
    endgenerate
    assign col_o[COL_W-1:BEAT_W] = base_i[COL_W-1:BEAT_W];
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    gen_state_t st_q, st_d;

    logic [BEAT_W-1:0] req_mask;
    logic              req_ok;
    logic              accept;
    logic [COL_W-1:0]  calc_base;
    logic [BEAT_W-1:0] calc_mask;
    logic              calc_ilv;
    logic [BEAT_W-1:0] calc_beat;
    logic [COL_W-1:0]  calc_col;
    logic [BEAT_W-1:0] beat_inc;

    burst_len_decode #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) i_dec (
        .code_i (len_i),
        .mask_o (req_mask),
        .ok_o   (req_ok)
    );

    assign accept   = start_i && req_ok && (!st_q.valid || st_q.last);
    assign beat_inc = st_q.beat + 1'b1;

    assign calc_base = accept ? col_i    : st_q.base;
    assign calc_mask = accept ? req_mask : st_q.mask;
    assign calc_ilv  = accept ? ilv_i    : st_q.ilv;
    assign calc_beat = accept ? '0       : beat_inc;

    burst_ord_calc #(.COL_W(COL_W), .BEAT_W(BEAT_W)) i_calc (
        .base_i (calc_base),
        .mask_i (calc_mask),
        .ilv_i  (calc_ilv),
        .beat_i (calc_beat),
        .col_o  (calc_col)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.last  = 1'b0;
            st_d.beat  = '0;
            st_d.mask  = req_mask;
            st_d.ilv   = ilv_i;
            st_d.base  = col_i;
            st_d.col   = calc_col;
        end else if (st_q.valid && !st_q.last) begin
            st_d.beat  = beat_inc;
            st_d.col   = calc_col;
            st_d.last  = (beat_inc == st_q.mask);
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_col_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_i,
    input logic [LEN_W-1:0] len_i,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] col_o
);
    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_block_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (valid_o && col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W])));

    p_drop_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && len_i == '0) |=> !valid_o);

    p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!valid_o || last_o) && start_i && len_i != '0) |=> (valid_o && col_o == $past(col_i)));
endmodule

bind burst_col_gen burst_col_gen_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (col_i),
    .len_i   (len_i),
    .valid_o (valid_o),
    .last_o  (last_o),
    .col_o   (col_o)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] col_i = '0;
    logic [1:0] len_i = '0;
    logic       ilv_i = 1'b0;
    logic [9:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .len_i(len_i), .ilv_i(ilv_i), .col_o(col_o),
        .valid_o(valid_o), .last_o(last_o)
    );

    function automatic logic [9:0] expect_col(input logic [9:0] c, input int code,
                                              input logic ilv, input int k);
        int m;
        int s;
        int off;
        m   = (1 << code) - 1;
        s   = int'(c) & m;
        off = ilv ? ((s ^ k) & m) : ((s + k) & m);
        return 10'((int'(c) & ~m) | off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Request at this negedge; on return the first beat is visible.
    task automatic request(input logic [9:0] c, input int code, input logic ilv);
        start_i = 1'b1;
        col_i   = c;
        len_i   = 2'(code);
        ilv_i   = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check a whole burst; on return we are one negedge after the final beat.
    // noise: raise a conflicting request on every non-final beat (R8).
    task automatic check_burst(input logic [9:0] c, input int code, input logic ilv,
                               input bit noise);
        int len;
        len = 1 << code;
        for (int k = 0; k < len; k++) begin
            chk("R2 valid", 32'(valid_o), 1);
            chk(ilv ? "R5 interleaved col" : "R4 sequential col",
                32'(col_o), 32'(expect_col(c, code, ilv, k)));
            chk("R6 upper bits", 32'(col_o >> code), 32'(c >> code));
            chk("R7 last flag", 32'(last_o), 32'(k == len - 1));
            if (noise && k != len - 1) begin
                start_i = 1'b1;
                col_i   = ~c;
                len_i   = 2'((code % 3) + 1);
                ilv_i   = ~ilv;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(valid_o), 0);
        chk("R1 last in reset", 32'(last_o), 0);
        chk("R1 col in reset", 32'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(valid_o), 0);
        chk("R1 col after reset", 32'(col_o), 0);

        // R2 R3 R4 R5 R6 R7 R11: full sweep
        for (int code = 1; code <= 3; code++) begin
            for (int ilv = 0; ilv < 2; ilv++) begin
                for (int s = 0; s < 8; s++) begin
                    for (int hi = 0; hi < 2; hi++) begin
                        logic [9:0] c;
                        c = hi ? 10'(10'h3F8 | s) : 10'(10'h0A8 | s);
                        request(c, code, 1'(ilv));
                        chk("R3 first beat", 32'(col_o), 32'(c));
                        check_burst(c, code, 1'(ilv), 1'b0);
                        chk("R11 valid drops", 32'(valid_o), 0);
                        chk("R11 last drops", 32'(last_o), 0);
                    end
                end
            end
        end

        // R8: conflicting requests during non-final beats are ignored
        for (int code = 1; code <= 3; code++) begin
            request(10'h155, code, 1'b1);
            check_burst(10'h155, code, 1'b1, 1'b1);
            chk("R8 no extra burst", 32'(valid_o), 0);
        end

        // R9: request on final beat chains with no gap
        request(10'h2C6, 2, 1'b0);
        for (int k = 0; k < 3; k++) @(negedge clk);
        chk("R9 on final beat", 32'(last_o), 1);
        start_i = 1'b1; col_i = 10'h01B; len_i = 2'd3; ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 gapless valid", 32'(valid_o), 1);
        chk("R9 new start column", 32'(col_o), 32'h01B);
        check_burst(10'h01B, 3, 1'b1, 1'b0);
        chk("R9 chain ends", 32'(valid_o), 0);

        // R10: reserved length code
        request(10'h3FF, 0, 1'b0);
        chk("R10 reserved ignored", 32'(valid_o), 0);
        @(negedge clk);
        chk("R10 still idle", 32'(valid_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule